// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block runs single conversions of an external 12-bit successive-approximation converter on one of three analog inputs. Software writes a channel-select bit and an enable bit into a control word. On the rising edge of enable the block routes the chosen input, waits through a startup interval, closes the sample switch for a sampling interval, then resolves the code one bit at a time, most significant bit first. For each bit trial it drives a trial code to an external DAC/comparator and reads back a single comparator bit.

All timing comes from a cycle-configuration word. It holds four values: a startup count, a sample-window count, a clock divider and a per-bit compare count. The divider sets the length of one conversion tick. The finished code goes to a result word owned by that channel, which carries a valid flag. A level interrupt reports each finished conversion when it is enabled, and software clears it by writing a one.

The register port is a plain single-cycle write strobe with a combinational read. It always accepts, so it has no valid/ready pair and no back-pressure. The analog side is plain control and status pins as well. One full-scale step of 3300 mV over 4096 codes gives an LSB of about 0.806 mV.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and the busy flag (status word 0x08, bit 0) is 0.
- R2: A write to the control word (0x04) that takes enable (bit 0) from 0 to 1 while exactly one select bit is set starts a conversion. Select bits 5, 6 and 7 pick channels 0, 1 and 2. Busy reads 1 in the cycle after the write.
- R3: An enable rising edge with no select bit set, or with more than one set, starts nothing: busy stays 0.
- R4: An enable rising edge while busy is ignored. The running conversion keeps its channel and its duration, no second conversion follows, and the other channels' result words are unchanged.
- R5: Busy stays high for exactly (S'+W'+12*C')*(D+1) clock cycles. S, W, D and C are the configuration fields startup (bits 4:0), window (bits 11:8), divider (bits 15:12) and compare (bits 19:16) of word 0x0C. X' means X, or 1 when X is 0.
- R6: The result is resolved MSB first. The trial code is the bits kept so far plus the bit under test. That bit is kept when `cmp_in` is 1 at the last clock of its compare period. With a comparator that reports input >= trial code, the result equals the input.
- R7: Each channel's result word (0x14 + 4*n) holds the code in bits 11:0 and a valid flag in bit 15. The valid flag clears when a conversion on that channel starts and sets when its result is written.
- R8: `sample_en` is high for exactly W'*(D+1) cycles per conversion, and `mux_sel` equals the selected channel throughout.
- R9: The interrupt status (0x28, bit 0) and `irq` set at the end of a conversion only if interrupt enable (0x20, bit 0) is 1.
- R10: Writing 1 to bit 0 of 0x24 clears the interrupt status. Writing 0 there has no effect.
- R11: The configuration word resets to zero and reads back only its four fields; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mux_sel | output | 2 | Analog input routed to the converter |
| sample_en | output | 1 | Sample switch closed |
| trial_code | output | 12 | Trial code driven to the DAC/comparator |
| cmp_in | input | 1 | Comparator result: 1 when input >= trial code |
| irq | output | 1 | Level interrupt, mirrors interrupt status |

## Verification
The assertions assume that `cmp_in` has settled at every rising clock edge during a compare period. They also assume that each register write is a single-cycle `bus_wr` pulse to a word-aligned address. The bench drives its comparator model combinationally from `trial_code` and `mux_sel`, so the decision is stable well before the sampling edge. It changes all bus inputs only on falling edges and drops `bus_wr` right after each rising edge. Configuration is rewritten only while idle, because the assertions about duration assume the latched fields hold for the whole conversion.

// File: rtl/sar_adc_pkg.sv
`timescale 1ns/1ps
package sar_adc_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int SEL_LSB = 5;
  localparam int VLD_BIT = 15;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] A_CYC  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_RES0 = 8'h14;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h20;
  localparam logic [ADDR_W-1:0] A_ICLR = 8'h24;
  localparam logic [ADDR_W-1:0] A_ISTA = 8'h28;

  typedef enum logic [1:0] {PH_IDLE, PH_STARTUP, PH_SAMPLE, PH_COMPARE} phase_e;

  typedef struct packed {
    logic [3:0] cmp_cyc;
    logic [3:0] div;
    logic [3:0] window;
    logic [4:0] startup;
  } cyc_cfg_t;

  function automatic logic [4:0] at_least_one(input logic [4:0] v);
    return (v == 5'd0) ? 5'd1 : v;
  endfunction
endpackage

// File: rtl/sar_tick.sv
`timescale 1ns/1ps
module sar_tick #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + DW'(1);
  end

  // R5: the prescaler never runs past the latched divider
  assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int RW  = 12,
  parameter int NCH = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW  = $clog2(RW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [CHW-1:0] start_ch_i,
  input  cyc_cfg_t       cfg_i,
  input  logic           tick_i,
  input  logic           cmp_i,
  output logic           busy_o,
  output logic [3:0]     div_o,
  output logic           done_o,
  output logic [CHW-1:0] chan_o,
  output logic [RW-1:0]  result_o,
  output logic           sample_o,
  output logic [RW-1:0]  trial_o
);
  phase_e         phase_q;
  cyc_cfg_t       cfg_q;
  logic [4:0]     cnt_q;
  logic [BW-1:0]  bit_q;
  logic [RW-1:0]  acc_q;
  logic [CHW-1:0] chan_q;
  logic [4:0]     limit;
  logic           phase_last;
  logic [RW-1:0]  bit_mask;

  always_comb begin
    case (phase_q)
      PH_STARTUP: limit = at_least_one(cfg_q.startup);
      PH_SAMPLE:  limit = at_least_one({1'b0, cfg_q.window});
      PH_COMPARE: limit = at_least_one({1'b0, cfg_q.cmp_cyc});
      default:    limit = 5'd1;
    endcase
  end

  assign phase_last = tick_i && (phase_q != PH_IDLE) && ((cnt_q + 5'd1) == limit);
  assign bit_mask   = RW'(1) << bit_q;
  assign result_o   = acc_q | (cmp_i ? bit_mask : '0);
  assign done_o     = (phase_q == PH_COMPARE) && phase_last && (bit_q == '0);
  assign busy_o     = (phase_q != PH_IDLE);
  assign sample_o   = (phase_q == PH_SAMPLE);
  assign trial_o    = (phase_q == PH_COMPARE) ? (acc_q | bit_mask) : '0;
  assign div_o      = cfg_q.div;
  assign chan_o     = chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      acc_q   <= '0;
      chan_q  <= '0;
    end else if (start_i && (phase_q == PH_IDLE)) begin
      phase_q <= PH_STARTUP;
      cfg_q   <= cfg_i;
      cnt_q   <= '0;
      bit_q   <= BW'(RW-1);
      acc_q   <= '0;
      chan_q  <= start_ch_i;
    end else if (tick_i && (phase_q != PH_IDLE)) begin
      if (phase_last) begin
        cnt_q <= '0;
        case (phase_q)
          PH_STARTUP: phase_q <= PH_SAMPLE;
          PH_SAMPLE: begin
            phase_q <= PH_COMPARE;
            bit_q   <= BW'(RW-1);
          end
          PH_COMPARE: begin
            acc_q <= result_o;
            if (bit_q == '0) phase_q <= PH_IDLE;
            else             bit_q   <= bit_q - BW'(1);
          end
          default: phase_q <= PH_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 5'd1;
      end
    end
  end

  // R6: the first trial after sampling tests the MSB alone
  assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_SAMPLE) && phase_last) |=> (trial_o == (RW'(1) << (RW-1))));
  // R5: the final bit decision ends the busy period
  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R4: the routed channel cannot move during a conversion
  assert_chan_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(chan_o));
endmodule

// File: rtl/sar_result_bank.sv
`timescale 1ns/1ps
module sar_result_bank #(
  parameter int RW  = 12,
  parameter int NCH = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic [CHW-1:0]          clr_ch_i,
  input  logic                    wr_i,
  input  logic [CHW-1:0]          wr_ch_i,
  input  logic [RW-1:0]           wr_data_i,
  output logic [NCH-1:0]          valid_o,
  output logic [NCH-1:0][RW-1:0]  code_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
        code_o[g]  <= '0;
      end else if (clr_i && (clr_ch_i == CHW'(g))) begin
        valid_o[g] <= 1'b0;
      end else if (wr_i && (wr_ch_i == CHW'(g))) begin
        valid_o[g] <= 1'b1;
        code_o[g]  <= wr_data_i;
      end
    end

    // R7: a start on this channel drops its valid flag
    assert_valid_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (clr_ch_i == CHW'(g))) |=> !valid_o[g]);
    // R7: a written result is flagged valid and held
    assert_valid_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clr_i && (wr_ch_i == CHW'(g))) |=> (valid_o[g] && (code_o[g] == $past(wr_data_i))));
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int CHANNELS = 3,
  localparam int CHW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [CHW-1:0]      mux_sel,
  output logic                sample_en,
  output logic [RES_BITS-1:0] trial_code,
  input  logic                cmp_in,
  output logic                irq
);
  logic                en_q;
  logic [CHANNELS-1:0] sel_q;
  cyc_cfg_t            cfg_q;
  logic                ien_q;
  logic                ist_q;

  logic                wr_ctrl, wr_cyc, wr_ien, wr_iclr;
  logic [CHANNELS-1:0] sel_w;
  logic                sel_one, en_rise, start;
  logic [CHW-1:0]      start_ch;

  logic                busy, done, tick;
  logic [3:0]          div;
  logic [RES_BITS-1:0] result;
  logic [CHANNELS-1:0] res_valid;
  logic [CHANNELS-1:0][RES_BITS-1:0] res_code;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:20];

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cyc  = bus_wr && (bus_addr == A_CYC);
  assign wr_ien  = bus_wr && (bus_addr == A_IEN);
  assign wr_iclr = bus_wr && (bus_addr == A_ICLR);

  assign sel_w   = bus_wdata[SEL_LSB +: CHANNELS];
  assign sel_one = (sel_w != '0) && ((sel_w & (sel_w - CHANNELS'(1))) == '0);
  assign en_rise = wr_ctrl && bus_wdata[0] && !en_q;
  assign start   = en_rise && sel_one && !busy;

  always_comb begin
    start_ch = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      if (sel_w[c]) start_ch = CHW'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      cfg_q <= '0;
      ien_q <= 1'b0;
      ist_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[0];
        sel_q <= sel_w;
      end
      if (wr_cyc) begin
        cfg_q.startup <= bus_wdata[4:0];
        cfg_q.window  <= bus_wdata[11:8];
        cfg_q.div     <= bus_wdata[15:12];
        cfg_q.cmp_cyc <= bus_wdata[19:16];
      end
      if (wr_ien) ien_q <= bus_wdata[0];
      if (done && ien_q)                 ist_q <= 1'b1;
      else if (wr_iclr && bus_wdata[0])  ist_q <= 1'b0;
    end
  end

  assign irq = ist_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0]                     = en_q;
        bus_rdata[SEL_LSB +: CHANNELS]   = sel_q;
      end
      A_STAT: bus_rdata[0] = busy;
      A_CYC: begin
        bus_rdata[4:0]   = cfg_q.startup;
        bus_rdata[11:8]  = cfg_q.window;
        bus_rdata[15:12] = cfg_q.div;
        bus_rdata[19:16] = cfg_q.cmp_cyc;
      end
      A_IEN:  bus_rdata[0] = ien_q;
      A_ISTA: bus_rdata[0] = ist_q;
      default: begin
        for (int c = 0; c < CHANNELS; c++) begin
          if (bus_addr == ADDR_W'(A_RES0 + ADDR_W'(4 * c))) begin
            bus_rdata[RES_BITS-1:0] = res_code[c];
            bus_rdata[VLD_BIT]      = res_valid[c];
          end
        end
      end
    endcase
  end

  sar_tick #(.DW(4)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .div_i  (div),
    .tick_o (tick)
  );

  sar_seq #(.RW(RES_BITS), .NCH(CHANNELS)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .start_ch_i (start_ch),
    .cfg_i      (cfg_q),
    .tick_i     (tick),
    .cmp_i      (cmp_in),
    .busy_o     (busy),
    .div_o      (div),
    .done_o     (done),
    .chan_o     (mux_sel),
    .result_o   (result),
    .sample_o   (sample_en),
    .trial_o    (trial_code)
  );

  sar_result_bank #(.RW(RES_BITS), .NCH(CHANNELS)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (start),
    .clr_ch_i  (start_ch),
    .wr_i      (done),
    .wr_ch_i   (mux_sel),
    .wr_data_i (result),
    .valid_o   (res_valid),
    .code_o    (res_code)
  );

  // R9: the interrupt only rises when it was enabled
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ien_q));
  // R3: a bad select pattern never starts a conversion
  assert_bad_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !sel_one && !busy) |=> !busy);
  // R4: an enable edge during a conversion neither stops nor restarts it
  assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && busy && !done) |=> busy);
  // R10: a clear with no competing completion drops the interrupt
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iclr && bus_wdata[0] && !done) |=> !irq);
  // R2: a legal enable edge while idle raises busy
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && sel_one && !busy) |=> busy);
endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
  import sar_adc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  mux_sel;
  logic        sample_en;
  logic [11:0] trial_code;
  logic        cmp_in;
  logic        irq;

  logic [11:0] vin [3];
  int          cmp_mode = 0;
  int          cur_ch = 0;
  int          samp_cnt = 0;
  int          sel_bad_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  typedef struct {int ch; int code; int cycles; int samp;} exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  assign cmp_in = (cmp_mode == 1) ? 1'b1 :
                  (cmp_mode == 2) ? 1'b0 : (vin[mux_sel] >= trial_code);

  sar_adc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mux_sel(mux_sel),
    .sample_en(sample_en), .trial_code(trial_code), .cmp_in(cmp_in), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n && sample_en) begin
      samp_cnt = samp_cnt + 1;
      if (int'(mux_sel) != cur_ch) sel_bad_cnt = sel_bad_cnt + 1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [31:0] cyc_word(input int s, input int w, input int dv, input int c);
    logic [31:0] r;
    r = '0;
    r[4:0] = s[4:0]; r[11:8] = w[3:0]; r[15:12] = dv[3:0]; r[19:16] = c[3:0];
    return r;
  endfunction

  // Driver: configures, starts a conversion and pushes the expected outcome
  task automatic run_conv(input int ch, input int code, input int s, input int w,
                          input int dv, input int c, input bit mid_check, input bit inject);
    logic [31:0] d;
    int busy_n, k;
    int sbase, selbase;
    bit fin;
    exp_t e;
    wr(A_CYC, cyc_word(s, w, dv, c));
    sb_q.push_back('{ch, code, (one(s) + one(w) + 12 * one(c)) * (dv + 1), one(w) * (dv + 1)});
    cur_ch = ch; sbase = samp_cnt; selbase = sel_bad_cnt;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, (32'h1 << (SEL_LSB + ch)) | 32'h1);
    busy_n = 0; k = 0; fin = 0;
    while (!fin && k < 5000) begin
      if (mid_check && k == 0) begin
        rd(A_RES0 + 8'(4 * ch), d);
        check("R7 valid cleared at start", {31'b0, d[VLD_BIT]}, 32'h0);
        busy_n++;
      end else if (inject && k == 3) begin
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, (32'h1 << (SEL_LSB + ((ch + 1) % 3))) | 32'h1);
        busy_n += 2; k++;
      end else begin
        rd(A_STAT, d);
        if (d[0]) busy_n++; else fin = 1;
      end
      k++;
    end
    // Monitor: pop the expected item and compare against what was produced
    e = sb_q.pop_front();
    check("R2 conversion started", {31'b0, busy_n > 0}, 32'h1);
    check("R5 busy duration", busy_n, e.cycles);
    rd(A_RES0 + 8'(4 * e.ch), d);
    check("R6 result code", {20'b0, d[11:0]}, e.code);
    check("R7 valid set at end", {31'b0, d[VLD_BIT]}, 32'h1);
    check("R8 sample window length", samp_cnt - sbase, e.samp);
    check("R8 mux_sel held on channel", sel_bad_cnt - selbase, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    vin[0] = 12'hABC; vin[1] = 12'h001; vin[2] = 12'hFFF;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl reset", d, 0);
    rd(A_STAT, d); check("R1 busy reset", d, 0);
    rd(A_CYC, d);  check("R1/R11 cyc reset", d, 0);
    for (int c = 0; c < 3; c++) begin
      rd(A_RES0 + 8'(4 * c), d); check("R1 result reset", d, 0);
    end
    rd(A_IEN, d);  check("R1 ien reset", d, 0);
    rd(A_ISTA, d); check("R1 ista reset", d, 0);
    check("R1 irq reset", {31'b0, irq}, 0);

    // R11 field masking
    wr(A_CYC, 32'hFFFF_FFFF);
    rd(A_CYC, d); check("R11 cyc readback mask", d, 32'h000F_FF1F);

    // Interrupt disabled: fastest timing, zero fields count as one
    run_conv(0, 12'hABC, 0, 0, 0, 0, 0, 0);
    check("R9 irq stays low when disabled", {31'b0, irq}, 0);
    rd(A_ISTA, d); check("R9 status stays low when disabled", d, 0);

    // Interrupt enabled, divided clock, mid-conversion valid check
    wr(A_IEN, 32'h1);
    run_conv(1, 12'h001, 3, 2, 1, 2, 1, 0);
    check("R9 irq after conversion", {31'b0, irq}, 1);
    rd(A_ISTA, d); check("R9 status after conversion", d, 1);
    wr(A_ICLR, 32'h0);
    rd(A_ISTA, d); check("R10 write zero keeps status", d, 1);
    wr(A_ICLR, 32'h1);
    rd(A_ISTA, d); check("R10 write one clears status", d, 0);
    check("R10 irq cleared", {31'b0, irq}, 0);

    // Longest default-style timing, full-scale input
    run_conv(2, 12'hFFF, 15, 15, 1, 15, 0, 0);
    check("R9 irq after long conversion", {31'b0, irq}, 1);
    wr(A_ICLR, 32'h1);

    // R4 enable edge while busy
    vin[0] = 12'h555;
    run_conv(0, 12'h555, 2, 1, 0, 1, 0, 1);
    repeat (20) @(posedge clk);
    rd(A_STAT, d); check("R4 no second conversion", d, 0);
    rd(A_RES0 + 8'd4, d); check("R4 other channel untouched", d, 32'h0000_8001);

    // R3 bad select patterns
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, d); check("R3 no select starts nothing", d, 0);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, (32'h3 << SEL_LSB) | 32'h1);
    rd(A_STAT, d); check("R3 two selects start nothing", d, 0);
    rd(A_RES0 + 8'd4, d); check("R3 results untouched", d, 32'h0000_8001);

    // R6 comparator stuck high then stuck low
    cmp_mode = 1;
    run_conv(1, 12'hFFF, 0, 0, 0, 0, 0, 0);
    cmp_mode = 2;
    run_conv(2, 12'h000, 1, 3, 2, 1, 0, 0);
    cmp_mode = 0;

    summary();
    $finish;
  end
endmodule